// File: doc/BRIEF.md
# Feedback Burst Completion Tracker

This block follows the feedback traffic of an iterative rotation loop. Each feedback burst is a fixed train of `2*NUM_CYCLE` beats. Feedback is issued more often than a burst lasts, so one burst can begin on the cycle right after the previous one ends, with valid never dropping. For that reason the block does not look for valid edges. It keeps a beat index that moves only on accepted beats. A burst counts as complete when a beat is accepted while that index sits at its last value.

A `start` pulse puts the block in its run state. When the loop controller has issued its last feedback, it pulses `loop_end`, and the block moves to a finish-wait state. The block stays there until the number of completed bursts equals `TARGET`. On that cycle it returns to idle, raises a single-cycle `done`, and clears both counters so the next invocation starts from zero.

Top module: `burst_done_tracker`

## Requirements
- R1: After reset the block is idle: `running` and `finwait` are low, `done` is low, and the beat index and burst count are zero.
- R2: Outside idle, a beat is accepted when `beat_valid` and `beat_ready` are both high. Each accepted beat moves the beat index up by one. After value `2*NUM_CYCLE-1` the index wraps to 0. Without an accepted beat the index holds.
- R3: Outside idle, the burst count rises by one on each accepted beat that has beat index `2*NUM_CYCLE-1`. This holds whether or not valid went low between bursts, so bursts sent back to back are counted one by one.
- R4: The burst count never goes above `TARGET`. It holds at `TARGET` when further bursts complete.
- R5: `start` moves the block from idle to run, so `running` is high on the next cycle. `loop_end` moves it from run to finish-wait, so `finwait` is high on the next cycle.
- R6: The block stays in finish-wait while the burst count is below `TARGET`. Beats accepted during finish-wait are still counted.
- R7: At a clock edge in finish-wait where the count equals `TARGET`, the block returns to idle. After that edge `done` is high for exactly one cycle, and the beat index and burst count read zero. A beat accepted on that same edge is dropped.
- R8: In idle, accepted beats change neither the beat index nor the burst count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Starts a loop invocation (used in idle) |
| loop_end_i | input | 1 | Last feedback has been issued (used in run) |
| beat_valid_i | input | 1 | Feedback beat valid |
| beat_ready_i | input | 1 | Feedback beat accepted by the consumer |
| beat_idx_o | output | $clog2(2*NUM_CYCLE) | Current beat index within the burst |
| burst_cnt_o | output | $clog2(TARGET+1) | Completed bursts |
| running_o | output | 1 | Run state |
| finwait_o | output | 1 | Finish-wait state |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Several rules are checked on every cycle by properties: the count never exceeds its target, the count rises only after an accepted beat at the last index, the index holds when no beat is accepted, nothing moves in idle, finish-wait is left only at the target, and `done` lasts one cycle and leaves clean counters. What the properties cannot show is that the final count equals the number of bursts actually sent. The bench shows this by sweeping inter-burst gaps from none to several cycles and by inserting ready stalls inside bursts. It also runs under-target runs that finish during finish-wait and over-target runs that saturate.

// File: rtl/fbc_pkg.sv
// Shared types for the feedback burst completion tracker.
package fbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_FINWAIT = 2'd2
    } fbc_state_t;
endpackage

// File: rtl/fbc_beat_ctr.sv
// Beat index within one feedback burst.
// Moves on accepted beats only and wraps after 2*NUM_CYCLE-1.
// Assumes clr_i has priority over any beat on the same edge.
module fbc_beat_ctr #(
    parameter int NUM_CYCLE = 32,
    localparam int IDX_W    = $clog2(2*NUM_CYCLE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    output logic             last_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(2*NUM_CYCLE-1);

    logic [IDX_W-1:0] idx_q;

    // Index register: clear, wrap at the last index, or step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            idx_q <= '0;
        else if (step_i)
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end

    // Flag the final beat position of a burst.
    always_comb last_o = (idx_q == LAST_IDX);

    assign idx_o = idx_q;
endmodule

// File: rtl/fbc_burst_ctr.sv
// Completed-burst counter, saturating at TARGET.
// Assumes the caller asserts done_beat_i only for an accepted beat at the last index.
module fbc_burst_ctr #(
    parameter int TARGET = 16,
    localparam int CNT_W = $clog2(TARGET+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             done_beat_i,
    output logic             at_target_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] TGT = CNT_W'(TARGET);

    logic [CNT_W-1:0] cnt_q;

    // Count bursts until the target is reached, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            cnt_q <= '0;
        else if (done_beat_i && cnt_q != TGT)
            cnt_q <= cnt_q + 1'b1;
    end

    // Target compare used by the finish-wait release.
    always_comb at_target_o = (cnt_q == TGT);

    assign cnt_o = cnt_q;
endmodule

// File: rtl/fbc_fsm.sv
// Idle / run / finish-wait sequencer.
// Leaves finish-wait when the burst count is at target. On that edge it asks
// for a counter clear and registers a one-cycle done pulse.
module fbc_fsm
    import fbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       loop_end_i,
    input  logic       at_target_i,
    output fbc_state_t state_o,
    output logic       release_o,
    output logic       done_o
);
    fbc_state_t state_q, state_d;
    logic       done_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)     state_d = ST_RUN;
            ST_RUN:     if (loop_end_i)  state_d = ST_FINWAIT;
            ST_FINWAIT: if (at_target_i) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // Release condition that clears both counters.
    always_comb release_o = (state_q == ST_FINWAIT) && at_target_i;

    // State and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= release_o;
        end
    end

    assign state_o = state_q;
    assign done_o  = done_q;
endmodule

// File: rtl/burst_done_tracker.sv
// Top level: counts completed fixed-length feedback bursts using a beat-index
// boundary, so overlapping back-to-back bursts are each counted. Counting runs
// in the run and finish-wait states only.
module burst_done_tracker
    import fbc_pkg::*;
#(
    parameter int NUM_CYCLE = 32,
    parameter int TARGET    = 16,
    localparam int IDX_W    = $clog2(2*NUM_CYCLE),
    localparam int CNT_W    = $clog2(TARGET+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             loop_end_i,
    input  logic             beat_valid_i,
    input  logic             beat_ready_i,
    output logic [IDX_W-1:0] beat_idx_o,
    output logic [CNT_W-1:0] burst_cnt_o,
    output logic             running_o,
    output logic             finwait_o,
    output logic             done_o
);
    fbc_state_t state;
    logic       release_w, at_target, last_beat, step;

    // A beat counts only when handshaken outside idle.
    always_comb step = beat_valid_i && beat_ready_i && (state != ST_IDLE);

    fbc_beat_ctr #(.NUM_CYCLE(NUM_CYCLE)) i_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (release_w),
        .step_i (step),
        .last_o (last_beat),
        .idx_o  (beat_idx_o)
    );

    fbc_burst_ctr #(.TARGET(TARGET)) i_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (release_w),
        .done_beat_i (step && last_beat),
        .at_target_o (at_target),
        .cnt_o       (burst_cnt_o)
    );

    fbc_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .loop_end_i  (loop_end_i),
        .at_target_i (at_target),
        .state_o     (state),
        .release_o   (release_w),
        .done_o      (done_o)
    );

    assign running_o = (state == ST_RUN);
    assign finwait_o = (state == ST_FINWAIT);
endmodule

// File: rtl/burst_done_tracker_chk.sv
// Port-level properties for burst_done_tracker, attached with bind.
module burst_done_tracker_chk #(
    parameter int NUM_CYCLE = 32,
    parameter int TARGET    = 16,
    localparam int IDX_W    = $clog2(2*NUM_CYCLE),
    localparam int CNT_W    = $clog2(TARGET+1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             beat_valid_i,
    input logic             beat_ready_i,
    input logic [IDX_W-1:0] beat_idx_o,
    input logic [CNT_W-1:0] burst_cnt_o,
    input logic             running_o,
    input logic             finwait_o,
    input logic             done_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(2*NUM_CYCLE-1);
    localparam logic [CNT_W-1:0] TGT      = CNT_W'(TARGET);

    logic idle, acc, leaving;
    always_comb begin
        idle    = !running_o && !finwait_o;
        acc     = beat_valid_i && beat_ready_i;
        leaving = finwait_o && (burst_cnt_o == TGT);
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        burst_cnt_o <= TGT);

    assert_count_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !idle && beat_idx_o == LAST_IDX && burst_cnt_o != TGT && !leaving)
        |=> burst_cnt_o == $past(burst_cnt_o) + 1'b1);

    assert_idx_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !leaving) |=> $stable(beat_idx_o));

    assert_idle_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> ($stable(beat_idx_o) && $stable(burst_cnt_o)));

    assert_exit_at_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (finwait_o && burst_cnt_o != TGT) |=> finwait_o);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (burst_cnt_o == '0 && beat_idx_o == '0 && idle));
endmodule

bind burst_done_tracker burst_done_tracker_chk #(
    .NUM_CYCLE (NUM_CYCLE),
    .TARGET    (TARGET)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat_valid_i (beat_valid_i),
    .beat_ready_i (beat_ready_i),
    .beat_idx_o   (beat_idx_o),
    .burst_cnt_o  (burst_cnt_o),
    .running_o    (running_o),
    .finwait_o    (finwait_o),
    .done_o       (done_o)
);

// File: tb/test_burst_done_tracker.sv
module test_burst_done_tracker;
    localparam int NC  = 2;
    localparam int TGT = 5;
    localparam int BL  = 2*NC;
    localparam int IW  = $clog2(BL);
    localparam int CW  = $clog2(TGT+1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, lend = 1'b0, vld = 1'b0, rdy = 1'b0;
    logic [IW-1:0] idx;
    logic [CW-1:0] cnt;
    logic run, fw, done;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    burst_done_tracker #(.NUM_CYCLE(NC), .TARGET(TGT)) i_burst_done_tracker (
        .clk(clk), .rst_n(rst_n), .start_i(start), .loop_end_i(lend),
        .beat_valid_i(vld), .beat_ready_i(rdy), .beat_idx_o(idx),
        .burst_cnt_o(cnt), .running_o(run), .finwait_o(fw), .done_o(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // Sends one burst; cnt_before is the count expected before its first beat.
    task automatic burst(input int cnt_before, input bit stall);
        for (int k = 0; k < BL; k++) begin
            if (stall && k == 1) begin
                vld = 1'b1; rdy = 1'b0;
                cyc();
                chk("R2 stall holds index", int'(idx), 1);
            end
            vld = 1'b1; rdy = 1'b1;
            cyc();
            chk("R2 index step/wrap", int'(idx), (k+1) % BL);
            chk("R3 count at boundary", int'(cnt),
                (k == BL-1) ? ((cnt_before+1 > TGT) ? TGT : cnt_before+1) : cnt_before);
        end
    endtask

    task automatic finish_release();
        cyc();
        chk("R7 done pulse", int'(done), 1);
        chk("R7 count cleared", int'(cnt), 0);
        chk("R7 index cleared", int'(idx), 0);
        chk("R7 back to idle", int'(fw | run), 0);
        cyc();
        chk("R7 done single cycle", int'(done), 0);
    endtask

    task automatic run_case(input int nb, input int gap, input bit stall);
        int c;
        start = 1'b1; cyc(); start = 1'b0;
        chk("R5 start enters run", int'(run), 1);
        c = 0;
        for (int b = 0; b < nb; b++) begin
            burst(c, stall);
            c = (c+1 > TGT) ? TGT : c+1;
            if (gap > 0) begin
                vld = 1'b0;
                for (int g = 0; g < gap; g++) begin
                    cyc();
                    chk("R2 gap holds index", int'(idx), 0);
                end
            end
        end
        vld = 1'b0;
        chk("R4 saturated count", int'(cnt), (nb > TGT) ? TGT : nb);
        lend = 1'b1; cyc(); lend = 1'b0;
        chk("R5 loop_end enters finwait", int'(fw), 1);
        if (c < TGT) begin
            for (int w = 0; w < 3; w++) begin
                cyc();
                chk("R6 finwait held below target", int'(fw), 1);
                chk("R6 no done below target", int'(done), 0);
            end
            for (int b = c; b < TGT; b++) burst(b, 1'b0);
            vld = 1'b0;
            chk("R6 counted in finwait", int'(cnt), TGT);
            chk("R6 still finwait at target edge", int'(fw), 1);
        end
        finish_release();
        // Idle: beats must be ignored.
        vld = 1'b1; rdy = 1'b1;
        for (int i = 0; i < 2*BL; i++) begin
            cyc();
            chk("R8 idle index", int'(idx), 0);
            chk("R8 idle count", int'(cnt), 0);
        end
        vld = 1'b0;
    endtask

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        chk("R1 running", int'(run), 0);
        chk("R1 finwait", int'(fw), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 index", int'(idx), 0);
        chk("R1 count", int'(cnt), 0);
        for (int gap = 0; gap < 4; gap++)
            for (int s = 0; s < 2; s++) begin
                run_case(TGT, gap, s[0]);
                run_case(TGT+2, gap, s[0]);
                run_case(TGT-2, gap, s[0]);
            end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule